// File: doc/BRIEF.md
# Lowest-Key Pitch Encoder with Scan-Time Offset

This block walks a row of keys one position per clock and picks the lowest key held down. The key index is never divided by twelve. Instead, a twelve-state note counter and an octave counter step forward together with the scan. When the lowest held key is seen, the two counts are captured, so the key arrives already split into a note code and an octave code. The note code drives a twelve-level converter, and the octave code selects the octave. A gate output tells whether any key was held during the last scan.

Each scan starts with a run of lead slots. A comparator trip pulse that arrives inside this window clears both counters at that moment. Every key is then encoded as if it sat several positions higher. Because the carry from the note counter runs straight into the octave counter, the shift crosses octave borders cleanly. The scanner outside the block reads `scanSlot` to choose which key line to present on `keyBit`.

Top module: `lownote_pitch_encoder`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `scanSlot`, `semiCode`, `octWord` and `gate` are all zero.
- R2: `scanSlot` counts 0 up to LEAD+NUM_KEYS-1 and then wraps to 0. Slots 0 to LEAD-1 form the lead window. In slot LEAD+k, `keyBit` carries key k, and 1 means pressed.
- R3: Among all keys pressed during a scan, only the lowest index k is encoded.
- R4: With position p = k + offset, `semiCode` equals p mod SEMIS, coded 0 to SEMIS-1, and `octWord` equals p / SEMIS.
- R5: The first cycle in the lead window with `offsetTrip` high, at slot j, sets offset = LEAD-1-j. A scan with no such cycle has offset 0.
- R6: Only the first trip of a scan counts. Later trips, and any trip at a slot of LEAD or above, have no effect on the result.
- R7: `keyBit` is ignored during the lead window.
- R8: `semiCode`, `octWord` and `gate` change only at the clock edge that ends the last slot. The new values are visible from slot 0 of the next scan.
- R9: A scan with no pressed key sets `gate` to 0 and leaves `semiCode` and `octWord` unchanged. A scan with a pressed key sets `gate` to 1.
- R10: `octWord` stops at its all-ones code instead of wrapping around. `semiCode` keeps following p mod SEMIS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, one slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| keyBit | input | 1 | Serial key state for the current slot, 1 = pressed |
| offsetTrip | input | 1 | Comparator trip pulse that clears the counters |
| scanSlot | output | clog2(LEAD+NUM_KEYS) (7) | Current slot, tells the scanner which key to present |
| semiCode | output | clog2(SEMIS) (4) | Latched note code, 0 to 11 |
| octWord | output | OCT_W (3) | Latched octave code, saturating |
| gate | output | 1 | High when the last scan found a pressed key |

## Verification
The bench keeps the full 49-key, 16-slot-lead scan and 12-note counter, but narrows the octave field to two bits. With only two bits, the top key and large offsets push the octave past code 3, so the saturation path is exercised. The long lead window lets one trip late in the window give no shift, while an early trip gives a shift of a full octave or more. Between these, the bench covers the first-trip-wins rule, note-counter wraps at 11→0, and scans with no key held.

// File: rtl/lnpe_pkg.sv
package lnpe_pkg;
  // strobes issued by the scan control toward the pitch datapath
  typedef struct packed {
    logic clear;     // end of scan: counters back to zero
    logic tripLoad;  // accepted offset trip: counters back to zero, counting starts
    logic advance;   // step note/octave counters
    logic capture;   // lowest pressed key seen in this slot
    logic publish;   // end of scan: move result to outputs
    logic hit;       // a key was found somewhere in this scan
  } strobe_t;
endpackage

// File: rtl/lnpe_scan_ctl.sv
module lnpe_scan_ctl
  import lnpe_pkg::*;
#(
  parameter int NUM_KEYS = 49,
  parameter int LEAD     = 16,
  localparam int FRAME   = LEAD + NUM_KEYS,
  localparam int SLOT_W  = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyBit,
  input  logic              offsetTrip,
  output logic [SLOT_W-1:0] scanSlot,
  output strobe_t           strb
);
  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(FRAME - 1);
  localparam logic [SLOT_W-1:0] LEAD_S = SLOT_W'(LEAD);

  logic [SLOT_W-1:0] slot;
  logic tripUsed, running, found;
  logic isLast, inLead;

  always_comb begin
    isLast        = (slot == LAST_S);
    inLead        = (slot < LEAD_S);
    strb.clear    = isLast;
    strb.publish  = isLast;
    strb.tripLoad = !isLast && inLead && offsetTrip && !tripUsed;
    strb.advance  = !isLast && !strb.tripLoad && (running || !inLead);
    strb.capture  = !inLead && keyBit && !found;
    strb.hit      = found || strb.capture;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot     <= '0;
      tripUsed <= 1'b0;
      running  <= 1'b0;
      found    <= 1'b0;
    end else if (isLast) begin
      slot     <= '0;
      tripUsed <= 1'b0;
      running  <= 1'b0;
      found    <= 1'b0;
    end else begin
      slot     <= slot + SLOT_W'(1);
      tripUsed <= tripUsed | strb.tripLoad;
      running  <= running | strb.tripLoad;
      found    <= found | strb.capture;
    end
  end

  assign scanSlot = slot;
endmodule

// File: rtl/lnpe_pitch_dp.sv
module lnpe_pitch_dp
  import lnpe_pkg::*;
#(
  parameter int SEMIS  = 12,
  parameter int OCT_W  = 3,
  localparam int SEMI_W = $clog2(SEMIS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [SEMI_W-1:0] semiCode,
  output logic [OCT_W-1:0]  octWord,
  output logic              gate
);
  localparam logic [SEMI_W-1:0] SEMI_TOP = SEMI_W'(SEMIS - 1);
  localparam logic [OCT_W-1:0]  OCT_TOP  = '1;

  logic [SEMI_W-1:0] semiCnt, semiInc, pendSemi, semiQ;
  logic [OCT_W-1:0]  octCnt, octInc, pendOct, octQ;
  logic              gateQ, semiWrap;

  always_comb begin
    semiWrap = (semiCnt == SEMI_TOP);
    semiInc  = semiWrap ? '0 : semiCnt + SEMI_W'(1);
    // octave carries on note wrap, held at its top code
    octInc   = (semiWrap && octCnt != OCT_TOP) ? octCnt + OCT_W'(1) : octCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      semiCnt  <= '0;
      octCnt   <= '0;
      pendSemi <= '0;
      pendOct  <= '0;
      semiQ    <= '0;
      octQ     <= '0;
      gateQ    <= 1'b0;
    end else begin
      if (strb.clear || strb.tripLoad) begin
        semiCnt <= '0;
        octCnt  <= '0;
      end else if (strb.advance) begin
        semiCnt <= semiInc;
        octCnt  <= octInc;
      end
      if (strb.capture) begin
        pendSemi <= semiCnt;
        pendOct  <= octCnt;
      end
      if (strb.publish) begin
        gateQ <= strb.hit;
        if (strb.hit) begin
          // a key found in the final slot has not reached the pending register yet
          semiQ <= strb.capture ? semiCnt : pendSemi;
          octQ  <= strb.capture ? octCnt  : pendOct;
        end
      end
    end
  end

  assign semiCode = semiQ;
  assign octWord  = octQ;
  assign gate     = gateQ;
endmodule

// File: rtl/lownote_pitch_encoder.sv
module lownote_pitch_encoder
  import lnpe_pkg::*;
#(
  parameter int NUM_KEYS = 49,
  parameter int LEAD     = 16,
  parameter int SEMIS    = 12,
  parameter int OCT_W    = 3,
  localparam int SLOT_W  = $clog2(LEAD + NUM_KEYS),
  localparam int SEMI_W  = $clog2(SEMIS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyBit,
  input  logic              offsetTrip,
  output logic [SLOT_W-1:0] scanSlot,
  output logic [SEMI_W-1:0] semiCode,
  output logic [OCT_W-1:0]  octWord,
  output logic              gate
);
  strobe_t strb;

  lnpe_scan_ctl #(.NUM_KEYS(NUM_KEYS), .LEAD(LEAD)) ctl_i (
    .clk(clk), .rstN(rstN), .keyBit(keyBit), .offsetTrip(offsetTrip),
    .scanSlot(scanSlot), .strb(strb)
  );

  lnpe_pitch_dp #(.SEMIS(SEMIS), .OCT_W(OCT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .semiCode(semiCode), .octWord(octWord), .gate(gate)
  );
endmodule

// File: rtl/lnpe_checker.sv
module lnpe_checker #(
  parameter int NUM_KEYS = 49,
  parameter int LEAD     = 16,
  parameter int SEMIS    = 12,
  parameter int OCT_W    = 3,
  localparam int SLOT_W  = $clog2(LEAD + NUM_KEYS),
  localparam int SEMI_W  = $clog2(SEMIS)
) (
  input logic              clk,
  input logic              rstN,
  input logic [SLOT_W-1:0] scanSlot,
  input logic [SEMI_W-1:0] semiCode,
  input logic [OCT_W-1:0]  octWord,
  input logic              gate
);
  localparam logic [SLOT_W-1:0] LAST_S   = SLOT_W'(LEAD + NUM_KEYS - 1);
  localparam logic [SEMI_W-1:0] SEMI_TOP = SEMI_W'(SEMIS - 1);

  // R2: slot wraps after the last one
  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (scanSlot == LAST_S) |=> (scanSlot == '0));

  // R2: slot otherwise steps by one
  a_r2_slot_step: assert property (@(posedge clk) disable iff (!rstN)
    (scanSlot != LAST_S) |=> (scanSlot == $past(scanSlot) + SLOT_W'(1)));

  // R8: outputs frozen inside a scan
  a_r8_hold_midscan: assert property (@(posedge clk) disable iff (!rstN)
    (scanSlot != LAST_S) |=> ($stable(semiCode) && $stable(octWord) && $stable(gate)));

  // R4: note code within the twelve levels
  a_r4_semi_range: assert property (@(posedge clk) disable iff (!rstN)
    semiCode <= SEMI_TOP);

  // R9: empty scan keeps the codes
  a_r9_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (scanSlot == LAST_S) |=> (gate || ($stable(semiCode) && $stable(octWord))));
endmodule

bind lownote_pitch_encoder lnpe_checker #(
  .NUM_KEYS(NUM_KEYS), .LEAD(LEAD), .SEMIS(SEMIS), .OCT_W(OCT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .scanSlot(scanSlot),
  .semiCode(semiCode), .octWord(octWord), .gate(gate)
);

// File: tb/lownote_pitch_encoder_tb.sv
`timescale 1ns/1ps
module lownote_pitch_encoder_tb_top;
  localparam int NUM_KEYS = 49;
  localparam int LEAD     = 16;
  localparam int SEMIS    = 12;
  localparam int OCT_W    = 2;
  localparam int FRAME    = LEAD + NUM_KEYS;
  localparam int SLOT_W   = $clog2(FRAME);
  localparam int OCT_MAX  = (1 << OCT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyBit = 1'b0;
  logic offsetTrip = 1'b0;
  logic [SLOT_W-1:0] scanSlot;
  logic [3:0] semiCode;
  logic [OCT_W-1:0] octWord;
  logic gate;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int expSemi = 0, expOct = 0, expGate = 0;

  always #4 clk = ~clk;

  lownote_pitch_encoder #(.NUM_KEYS(NUM_KEYS), .LEAD(LEAD), .SEMIS(SEMIS), .OCT_W(OCT_W)) dut_i (
    .clk(clk), .rstN(rstN), .keyBit(keyBit), .offsetTrip(offsetTrip),
    .scanSlot(scanSlot), .semiCode(semiCode), .octWord(octWord), .gate(gate)
  );

  function automatic int packOut(int s, int o, int g);
    return s * 100 + o * 10 + g;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tag);
    int act = packOut(int'(semiCode), int'(octWord), int'(gate));
    int exp = packOut(expSemi, expOct, expGate);
    check(act == exp, tag, act, exp);
  endtask

  // one full scan; starts and ends at a falling edge in slot 0
  task automatic runScan(input logic [NUM_KEYS-1:0] keys, input int t1, input int t2,
                         input bit leadNoise);
    int lowKey = -1;
    int first = -1;
    for (int s = 0; s < FRAME; s++) begin
      checkOut("R8 outputs steady within scan");
      check(int'(scanSlot) == s, "R2 slot sequence", int'(scanSlot), s);
      keyBit     = (s >= LEAD) ? keys[s-LEAD] : leadNoise;
      offsetTrip = (s == t1) || (s == t2);
      @(posedge clk);
      if (s == FRAME - 1) begin
        for (int k = NUM_KEYS - 1; k >= 0; k--) if (keys[k]) lowKey = k;
        if (t1 >= 0 && t1 < LEAD) first = t1;
        if (t2 >= 0 && t2 < LEAD && (first < 0 || t2 < first)) first = t2;
        if (lowKey >= 0) begin
          int p = lowKey + ((first >= 0) ? (LEAD - 1 - first) : 0);
          expSemi = p % SEMIS;
          expOct  = (p / SEMIS > OCT_MAX) ? OCT_MAX : p / SEMIS;
          expGate = 1;
        end else begin
          expGate = 0;
        end
      end
      @(negedge clk);
    end
    keyBit = 1'b0;
    offsetTrip = 1'b0;
  endtask

  function automatic logic [NUM_KEYS-1:0] one(input int k);
    logic [NUM_KEYS-1:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(int'(scanSlot) == 0, "R1 reset slot", int'(scanSlot), 0);
    checkOut("R1 reset outputs");
    rstN = 1'b1;
    checkOut("R1 first cycle after reset");

    runScan(one(0), -1, -1, 0);
    checkOut("R4 key 0 gives note 0 octave 0");
    runScan(one(13) | one(30), -1, -1, 0);
    checkOut("R3 lowest of two keys wins");
    runScan('0, -1, -1, 0);
    checkOut("R9 empty scan drops gate and holds codes");
    runScan(one(11), -1, -1, 0);
    checkOut("R4 top note of first octave");
    runScan(one(12), -1, -1, 0);
    checkOut("R4 note wrap carries into octave");
    runScan(one(8), 10, -1, 0);
    checkOut("R5 offset five moves across octave border");
    runScan(one(0), 3, 10, 0);
    checkOut("R6 second trip in window ignored");
    runScan(one(5), 20, -1, 0);
    checkOut("R6 trip after window ignored");
    runScan(one(40), -1, -1, 1);
    checkOut("R7 lead-window key bits ignored");
    runScan(one(48), 0, -1, 0);
    checkOut("R10 large offset saturates octave");
    runScan(one(47), -1, -1, 0);
    checkOut("R4 key 47 last note of top octave");
    runScan(one(48), -1, -1, 0);
    checkOut("R10 top key saturates octave");
    runScan(one(2), 15, -1, 0);
    checkOut("R5 trip in last lead slot gives no shift");
    runScan('0, 2, -1, 1);
    checkOut("R9 empty scan with trip holds codes");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule